// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns three reset causes into ordered clear strobes for the register groups of a network controller core. The first cause is an external reset pin, which counts only once it has been held low long enough. The second is a read of a dedicated reset register. The third is a 0-to-1 write of a stop control bit. Each cause clears its own set of register groups. The groups are presented as one strobe vector, and the register files themselves stay outside the block.

Each reset opens with a one-cycle clear strobe. The strobe comes with a restart pulse for the core's sequencer, and the pin reset also forces the link unit into its failed state. A one-cycle done pulse follows, tagged with the kind of reset. A pin reset then raises a request for the EEPROM loader and holds it until the loader acknowledges.

The software reset pulls the bus request line low at once. A stop reset leaves the bus request alone and waits until the bus is granted and no master transfer is still scheduled.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A pin reset takes effect only if `pin_rst_n` was sampled low on at least `MIN_PW` consecutive rising edges before it is sampled high. Shorter pulses produce no strobe.
- R2: A qualified pin reset drives `clr_grp` to 4'b1111 in the cycle after `pin_rst_n` is sampled high. `link_fail` and `core_restart` are high in that same cycle. Group bits: [0] configuration space, [1] bus configuration, [2] bulk control/status, [3] core control/status subset.
- R3: Every reset holds `clr_grp` nonzero for exactly one cycle and then asserts `done` for one cycle. `done_kind` reads 2'b01 for pin, 2'b10 for software and 2'b11 for stop, and 2'b00 while `done` is low.
- R4: `ee_req` rises in the cycle after a pin-reset `done` and stays high until `ee_ack` is sampled. Software and stop resets never raise it.
- R5: A sampled `rstreg_rd` drives `clr_grp` to 4'b1100 in the next cycle, with `core_restart` high and `link_fail` low.
- R6: `bus_req` is low in any cycle where `rstreg_rd` is high. It stays low through the strobe and done cycles of a software reset. Otherwise `bus_req` follows `bus_req_in`.
- R7: `stop_wr` loads `stop_wdata` into `stop_bit`. Only a write of 1 while `stop_bit` is 0 requests a stop reset. A write of 1 while `stop_bit` is 1 has no effect.
- R8: A requested stop reset waits while `mst_pending` is high, and also while `bus_req_in` is high and `bus_gnt` is low. During the wait `bus_req` is not dropped. Once the condition is sampled clear, `clr_grp` is 4'b1000 in the following cycle.
- R9: A qualified pin reset cancels a pending stop reset, so no 4'b1000 strobe follows. The pin reset also clears `stop_bit` to 0.
- R10: A software reset taken while a stop reset is pending discards the stop. `stop_bit` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| pin_rst_n | input | 1 | External reset pin, active low, already synchronous to clk |
| rstreg_rd | input | 1 | Read strobe of the reset register |
| stop_wr | input | 1 | Write strobe of the stop bit |
| stop_wdata | input | 1 | Value written to the stop bit |
| mst_pending | input | 1 | Scheduled master transfers remain |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_req_in | input | 1 | Bus request from the DMA engine |
| ee_ack | input | 1 | EEPROM loader accepted the request |
| bus_req | output | 1 | Bus request toward the arbiter |
| stop_bit | output | 1 | Current stop bit value |
| clr_grp | output | 4 | One-cycle clear strobes per register group |
| core_restart | output | 1 | Restart pulse for the core sequencer |
| link_fail | output | 1 | Forces the link unit to its failed state |
| ee_req | output | 1 | EEPROM autoload request |
| done | output | 1 | One-cycle completion pulse |
| done_kind | output | 2 | Kind of the completed reset |

## Verification
The hardest situations to reach are a stop reset left pending behind outstanding master transfers while a pin reset or a software reset arrives. The stimulus holds `mst_pending` and the grant in a blocking state, issues the stop write, fires the competing reset, and then releases the blocking inputs. Any late 4'b1000 strobe would show up at that point. Randomised pulse widths on both sides of `MIN_PW` probe the qualification edge. Randomised blocking intervals check that the stop fires exactly one cycle after release.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam int NGRP       = 4;
  localparam int G_CFG      = 0;
  localparam int G_BUSCFG   = 1;
  localparam int G_CSR_BULK = 2;
  localparam int G_CSR_CORE = 3;

  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_HW   = 2'b01,
    K_SW   = 2'b10,
    K_STOP = 2'b11
  } rst_kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_CLEAR = 2'b01,
    S_DONE  = 2'b10
  } seq_state_e;

  function automatic logic [NGRP-1:0] grp_mask(rst_kind_e k);
    logic [NGRP-1:0] m;
    m = '0;
    case (k)
      K_HW:    m = '1;
      K_SW:    begin
                 m[G_CSR_BULK] = 1'b1;
                 m[G_CSR_CORE] = 1'b1;
               end
      K_STOP:  m[G_CSR_CORE] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
  parameter int MIN_PW = 8
) (
  input  logic clk,
  input  logic srst_n,
  input  logic pin_n,
  output logic hw_evt
);
  localparam int CW = $clog2(MIN_PW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_PW);

  logic [CW-1:0] cnt_q, cnt_d;

  // saturating count of low samples; cleared when the pin is high
  always_comb begin
    cnt_d = cnt_q;
    if (pin_n)
      cnt_d = '0;
    else if (cnt_q != LIMIT)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign hw_evt = pin_n && (cnt_q == LIMIT);
endmodule

// File: rtl/rst_stop_ctl.sv
module rst_stop_ctl (
  input  logic clk,
  input  logic srst_n,
  input  logic stop_wr,
  input  logic stop_wdata,
  input  logic hw_evt,
  input  logic hw_clear,
  input  logic sw_take,
  input  logic stop_take,
  input  logic mst_pending,
  input  logic bus_gnt,
  input  logic bus_req_in,
  output logic stop_bit,
  output logic stop_go
);
  logic bit_q, bit_d;
  logic pend_q, pend_d;
  logic set_req;

  assign set_req = stop_wr && stop_wdata && !bit_q;

  always_comb begin
    bit_d = bit_q;
    if (hw_clear)
      bit_d = 1'b0;
    else if (stop_wr)
      bit_d = stop_wdata;
  end

  always_comb begin
    pend_d = pend_q;
    if (hw_evt || sw_take)
      pend_d = 1'b0;
    else if (set_req)
      pend_d = 1'b1;
    else if (stop_take)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bit_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      pend_q <= pend_d;
    end
  end

  assign stop_bit = bit_q;
  assign stop_go  = pend_q && !mst_pending && (bus_gnt || !bus_req_in);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic            clk,
  input  logic            srst_n,
  input  logic            hw_evt,
  input  logic            sw_rd,
  input  logic            stop_go,
  input  logic            ee_ack,
  output logic [NGRP-1:0] clr_grp,
  output logic            core_restart,
  output logic            link_fail,
  output logic            done,
  output logic [1:0]      done_kind,
  output logic            ee_req,
  output logic            sw_busy,
  output logic            sw_take,
  output logic            stop_take,
  output logic            hw_clear
);
  seq_state_e state_q, state_d;
  rst_kind_e  kind_q, kind_d;
  logic       ee_q, ee_d;
  logic       idle;

  assign idle      = (state_q == S_IDLE);
  assign sw_take   = idle && sw_rd && !hw_evt;
  assign stop_take = idle && stop_go && !hw_evt && !sw_rd;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    if (hw_evt) begin
      state_d = S_CLEAR;
      kind_d  = K_HW;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (sw_rd) begin
            state_d = S_CLEAR;
            kind_d  = K_SW;
          end else if (stop_go) begin
            state_d = S_CLEAR;
            kind_d  = K_STOP;
          end
        end
        S_CLEAR: state_d = S_DONE;
        S_DONE:  state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_comb begin
    ee_d = ee_q;
    if (state_q == S_CLEAR && kind_q == K_HW)
      ee_d = 1'b0;
    else if (state_q == S_DONE && kind_q == K_HW)
      ee_d = 1'b1;
    else if (ee_ack)
      ee_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_NONE;
      ee_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      ee_q    <= ee_d;
    end
  end

  assign clr_grp      = (state_q == S_CLEAR) ? grp_mask(kind_q) : '0;
  assign core_restart = (state_q == S_CLEAR);
  assign hw_clear     = (state_q == S_CLEAR) && (kind_q == K_HW);
  assign link_fail    = hw_clear;
  assign done         = (state_q == S_DONE);
  assign done_kind    = done ? kind_q : K_NONE;
  assign ee_req       = ee_q;
  assign sw_busy      = !idle && (kind_q == K_SW);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int MIN_PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_rst_n,
  input  logic            rstreg_rd,
  input  logic            stop_wr,
  input  logic            stop_wdata,
  input  logic            mst_pending,
  input  logic            bus_gnt,
  input  logic            bus_req_in,
  input  logic            ee_ack,
  output logic            bus_req,
  output logic            stop_bit,
  output logic [NGRP-1:0] clr_grp,
  output logic            core_restart,
  output logic            link_fail,
  output logic            ee_req,
  output logic            done,
  output logic [1:0]      done_kind
);
  logic [1:0] rs_q;
  logic       srst_n;
  logic       hw_evt, stop_go, sw_busy, sw_take, stop_take, hw_clear;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  rst_pin_qual #(.MIN_PW(MIN_PW)) i_qual (
    .clk    (clk),
    .srst_n (srst_n),
    .pin_n  (pin_rst_n),
    .hw_evt (hw_evt)
  );

  rst_stop_ctl i_stop (
    .clk         (clk),
    .srst_n      (srst_n),
    .stop_wr     (stop_wr),
    .stop_wdata  (stop_wdata),
    .hw_evt      (hw_evt),
    .hw_clear    (hw_clear),
    .sw_take     (sw_take),
    .stop_take   (stop_take),
    .mst_pending (mst_pending),
    .bus_gnt     (bus_gnt),
    .bus_req_in  (bus_req_in),
    .stop_bit    (stop_bit),
    .stop_go     (stop_go)
  );

  rst_seq_fsm i_fsm (
    .clk          (clk),
    .srst_n       (srst_n),
    .hw_evt       (hw_evt),
    .sw_rd        (rstreg_rd),
    .stop_go      (stop_go),
    .ee_ack       (ee_ack),
    .clr_grp      (clr_grp),
    .core_restart (core_restart),
    .link_fail    (link_fail),
    .done         (done),
    .done_kind    (done_kind),
    .ee_req       (ee_req),
    .sw_busy      (sw_busy),
    .sw_take      (sw_take),
    .stop_take    (stop_take),
    .hw_clear     (hw_clear)
  );

  // software reset removes the request immediately; stop leaves it alone
  assign bus_req = bus_req_in && !rstreg_rd && !sw_busy;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_rst_n,
  input logic       rstreg_rd,
  input logic       mst_pending,
  input logic       hw_evt,
  input logic       bus_req,
  input logic [3:0] clr_grp,
  input logic       core_restart,
  input logic       link_fail,
  input logic       ee_req,
  input logic       done,
  input logic [1:0] done_kind
);
  // R1: a pin event needs the pin to have been low on the previous sample
  a_r1_pin_was_low: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |-> $past(!pin_rst_n));

  // R2: link fail only with the full group mask and a sequencer restart
  a_r2_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> (clr_grp == 4'b1111 && core_restart));

  // R3: a strobe is followed by done unless a new pin reset restarts it
  a_r3_strobe_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_grp != 4'b0000 && !hw_evt) |=> (done && clr_grp == 4'b0000));

  // R3: done carries a kind and never overlaps a strobe
  a_r3_done_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_kind != 2'b00 && clr_grp == 4'b0000));

  // R4: the EEPROM request rises only after a pin reset completes
  a_r4_ee_after_hw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_req) |-> $past(done && done_kind == 2'b01));

  // R6: a reset-register read drops the bus request in the same cycle
  a_r6_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rstreg_rd |-> !bus_req);

  // R8: a stop strobe only follows a sample with no pending transfers
  a_r8_stop_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_grp == 4'b1000) |-> $past(!mst_pending));

  // R9: a pin reset is never followed directly by a stop strobe
  a_r9_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> (clr_grp == 4'b1111));
endmodule

bind rst_seq_ctrl rst_seq_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_rst_n    (pin_rst_n),
  .rstreg_rd    (rstreg_rd),
  .mst_pending  (mst_pending),
  .hw_evt       (hw_evt),
  .bus_req      (bus_req),
  .clr_grp      (clr_grp),
  .core_restart (core_restart),
  .link_fail    (link_fail),
  .ee_req       (ee_req),
  .done         (done),
  .done_kind    (done_kind)
);

// File: tb/test_rst_seq_ctrl.sv
`timescale 1ns/1ps
module test_rst_seq_ctrl;
  localparam int MIN_PW = 8;

  logic clk = 1'b0;
  logic rst_n, pin_rst_n, rstreg_rd, stop_wr, stop_wdata;
  logic mst_pending, bus_gnt, bus_req_in, ee_ack;
  logic bus_req, stop_bit, core_restart, link_fail, ee_req, done;
  logic [3:0] clr_grp;
  logic [1:0] done_kind;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rst_seq_ctrl #(.MIN_PW(MIN_PW)) i_rst_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .rstreg_rd(rstreg_rd),
    .stop_wr(stop_wr), .stop_wdata(stop_wdata), .mst_pending(mst_pending),
    .bus_gnt(bus_gnt), .bus_req_in(bus_req_in), .ee_ack(ee_ack),
    .bus_req(bus_req), .stop_bit(stop_bit), .clr_grp(clr_grp),
    .core_restart(core_restart), .link_fail(link_fail), .ee_req(ee_req),
    .done(done), .done_kind(done_kind)
  );

  function automatic logic [3:0] mask_of(input logic [1:0] kind);
    case (kind)
      2'b01:   return 4'b1111;
      2'b10:   return 4'b1100;
      2'b11:   return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] hw_expect(input int len);
    return (len >= MIN_PW) ? mask_of(2'b01) : 4'b0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic ack_ee();
    ee_ack = 1'b1;
    @(negedge clk);
    ee_ack = 1'b0;
    check("R4 ee_req cleared by ack", ee_req, 1'b0);
  endtask

  task automatic hw_pulse(input int len);
    logic [3:0] e;
    e = hw_expect(len);
    pin_rst_n = 1'b0;
    repeat (len) @(negedge clk);
    pin_rst_n = 1'b1;
    @(negedge clk);
    check("R1 R2 pin strobe mask", clr_grp, e);
    check("R2 link_fail", link_fail, e[0]);
    check("R2 core_restart", core_restart, e[0]);
    @(negedge clk);
    check("R3 hw done", done, e[0]);
    check("R3 hw done_kind", done_kind, e[0] ? 2'b01 : 2'b00);
    check("R3 no second strobe", clr_grp, 4'b0000);
    @(negedge clk);
    check("R4 ee_req after hw done", ee_req, e[0]);
    if (e[0]) ack_ee();
  endtask

  task automatic sw_read();
    bus_req_in = 1'b1;
    rstreg_rd = 1'b1;
    #1;
    check("R6 bus_req low with read", bus_req, 1'b0);
    @(negedge clk);
    rstreg_rd = 1'b0;
    #1;
    check("R5 sw strobe mask", clr_grp, 4'b1100);
    check("R5 sw core_restart", core_restart, 1'b1);
    check("R5 sw link_fail low", link_fail, 1'b0);
    check("R6 bus_req low in strobe", bus_req, 1'b0);
    @(negedge clk);
    check("R3 sw done_kind", {done, done_kind}, 3'b110);
    check("R6 bus_req low in done", bus_req, 1'b0);
    @(negedge clk);
    check("R6 bus_req follows after sw", bus_req, 1'b1);
    check("R4 no ee_req after sw", ee_req, 1'b0);
  endtask

  task automatic stop_write(input logic v);
    stop_wr = 1'b1;
    stop_wdata = v;
    @(negedge clk);
    stop_wr = 1'b0;
    stop_wdata = 1'b0;
  endtask

  task automatic stop_wait(input int w);
    mst_pending = 1'b1;
    bus_req_in = 1'b1;
    bus_gnt = 1'b1;
    stop_write(1'b1);
    check("R7 stop_bit set", stop_bit, 1'b1);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      check("R8 stop held by transfers", clr_grp, 4'b0000);
      check("R8 bus_req kept", bus_req, 1'b1);
    end
    mst_pending = 1'b0;
    @(negedge clk);
    check("R8 stop strobe after drain", clr_grp, mask_of(2'b11));
    check("R8 stop leaves link", link_fail, 1'b0);
    @(negedge clk);
    check("R3 stop done_kind", {done, done_kind}, 3'b111);
    @(negedge clk);
    check("R4 no ee_req after stop", ee_req, 1'b0);
    stop_write(1'b0);
    check("R7 stop_bit cleared by write", stop_bit, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pin_rst_n = 1'b1; rstreg_rd = 1'b0; stop_wr = 1'b0;
    stop_wdata = 1'b0; mst_pending = 1'b0; bus_gnt = 1'b0;
    bus_req_in = 1'b0; ee_ack = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R3 reset clr_grp", clr_grp, 4'b0000);
    check("R3 reset done", done, 1'b0);
    check("R4 reset ee_req", ee_req, 1'b0);
    check("R7 reset stop_bit", stop_bit, 1'b0);
    bus_req_in = 1'b1;
    #1;
    check("R6 bus_req follows input", bus_req, 1'b1);

    // R1: boundary widths around the threshold
    hw_pulse(MIN_PW - 1);
    hw_pulse(MIN_PW);
    hw_pulse(1);

    // R5 R6: software reset
    @(negedge clk);
    sw_read();

    // R7 R8: immediate stop, then rewrite of 1 while already 1
    bus_req_in = 1'b0; mst_pending = 1'b0;
    stop_write(1'b1);
    @(negedge clk);
    check("R7 stop strobe", clr_grp, 4'b1000);
    @(negedge clk);
    @(negedge clk);
    stop_write(1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 rewrite of 1 ignored", {clr_grp, done}, 5'b00000);
    end
    stop_write(1'b0);

    // R8: wait for grant while requesting
    bus_req_in = 1'b1; bus_gnt = 1'b0;
    stop_write(1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 stop held without grant", clr_grp, 4'b0000);
      check("R8 bus_req kept without grant", bus_req, 1'b1);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    check("R8 stop after grant", clr_grp, 4'b1000);
    repeat (2) @(negedge clk);
    stop_write(1'b0);

    // R9: pin reset cancels a pending stop
    mst_pending = 1'b1;
    stop_write(1'b1);
    hw_pulse(MIN_PW + 2);
    check("R9 stop_bit cleared by pin reset", stop_bit, 1'b0);
    mst_pending = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 no stop after pin reset", clr_grp, 4'b0000);
    end

    // R10: software reset discards a pending stop
    mst_pending = 1'b1;
    stop_write(1'b1);
    sw_read();
    check("R10 stop_bit unchanged", stop_bit, 1'b1);
    mst_pending = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R10 no stop after sw", clr_grp, 4'b0000);
    end
    stop_write(1'b0);

    // random widths and drain intervals
    for (int n = 0; n < 20; n++) begin
      hw_pulse(int'($urandom_range(1, 2 * MIN_PW)));
      @(negedge clk);
    end
    for (int n = 0; n < 20; n++) begin
      stop_wait(int'($urandom_range(0, 12)));
      @(negedge clk);
    end

    finish_run();
  end
endmodule